// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Command Port

This block is the slave-mode serial port of a delta-sigma converter. An external controller drives the serial clock and an active-low chip select. The port sees them only through the converter's master clock. It holds a four-byte command register and drives an active-low data-ready strobe. A down-counter on the master clock paces that strobe, and it reloads from the decimation ratio and speed-up fields of the register.

Each transfer has two phases. First comes an 8-bit instruction byte. Its top bit gives the direction and its low bits give the target byte and the byte count. Zero, one or three data bytes follow, written into or read out of the register. A transfer is accepted only while data-ready is low and a short guard time has passed since it fell. Finishing a transfer sends data-ready high again. Read data leaves on a bidirectional data pin (with its own output enable) or on a separate output pin, as a register bit selects.

Top module: `dsadc_serial_port`

## Requirements
- R1: A synchronous active-high reset sets the register to byte3=00h, byte2=00h, byte1=00h, byte0=17h, drives drdy_n high and holds sdio_oe and sdout low.
- R2: Every byte moves most significant bit first. Input bits are taken on rising serial-clock edges. A read byte's first bit appears after the rising edge that ends the byte before it, and each later bit appears after a falling edge.
- R3: Instruction bit 7 picks read (1) or write (0). Bits 2:0 pick the target: 111 is byte0, 110 is byte1 and 100 is byte3, each moving one byte. 101 moves three bytes in the order byte2, byte1, byte0.
- R4: An instruction with bit 2 clear carries no data bytes. The transfer is complete after its eighth bit and no register byte changes.
- R5: data-ready falls each time the timer expires. The period in master-clock cycles is ((ratio+1)*PRESCALE)>>t, but never below MIN_PERIOD. Here ratio = {byte2[2:0], byte0} and t = min(byte1[7:5], 4), so byte1 = 80h gives a period 16 times shorter. A new value takes effect from the next expiry.
- R6: drdy_n goes high right after the last rising serial-clock edge of a complete transfer. Otherwise it stays low until the next expiry.
- R7: Serial-clock rising edges are ignored while drdy_n is high, and during the first GUARD (6) master-clock cycles after drdy_n falls.
- R8: Raising cs_n in the middle of a transfer drops it. No byte is written, the next transfer starts with a fresh instruction, and drdy_n stays low.
- R9: When byte3 bit 6 is 1, read data leaves on sdout and sdio_oe stays low. When it is 0, read data leaves on sdio_out with sdio_oe high during read bytes, and sdout stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Input side of the bidirectional data pin |
| sdio_out | output | 1 | Output side of the bidirectional data pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional data pin |
| sdout | output | 1 | Separate serial read-data pin |
| drdy_n | output | 1 | Active-low data-ready strobe |

## Verification
The assertions assume the serial inputs are slow next to the master clock. Each serial-clock level must last several master-clock cycles, longer than the synchronizer plus one register. The data input must be steady around rising edges, and chip select may change only while the serial clock is low.

The stimulus keeps to these rules. It holds each serial-clock level for six master-clock cycles and changes data and chip select only in the low phase. It opens each transfer ten cycles after data-ready falls. The two cases that break the guard window are made on purpose and carry their own checks: early edges right after the fall, and edges while data-ready is high.

// File: rtl/dsadc_sp_pkg.sv
package dsadc_sp_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned NUM_BYTES   = 4;
    localparam int unsigned ADDR_W      = $clog2(NUM_BYTES);
    localparam int unsigned RATIO_HI_W  = 3;
    localparam int unsigned RATIO_W     = BYTE_W + RATIO_HI_W;
    localparam int unsigned SHIFT_W     = 3;
    localparam int unsigned SHIFT_MAX   = 4;
    localparam int unsigned OUTSEL_BIT  = 6;
    localparam logic [NUM_BYTES*BYTE_W-1:0] CMD_RESET = 32'h0000_0017;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INSTR = 2'd1,
        ST_DATA  = 2'd2,
        ST_DONE  = 2'd3
    } xfer_st_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        nbytes;
    } instr_t;

    typedef struct packed {
        logic [BYTE_W-1:0] b3;
        logic [BYTE_W-1:0] b2;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b0;
    } cmd_reg_t;

    // low bits 11 -> byte0, 10 -> byte1, 01 -> byte2 (three-byte run), 00 -> byte3
    function automatic instr_t decode_instr(input logic [BYTE_W-1:0] code);
        instr_t d;
        d.rd   = code[BYTE_W-1];
        d.addr = ~code[ADDR_W-1:0];
        if (!code[2])
            d.nbytes = 2'd0;
        else if (code[1:0] == 2'b01)
            d.nbytes = 2'd3;
        else
            d.nbytes = 2'd1;
        return d;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_of(input cmd_reg_t r);
        return {r.b2[RATIO_HI_W-1:0], r.b0};
    endfunction

    function automatic logic [SHIFT_W-1:0] shift_of(input cmd_reg_t r);
        logic [SHIFT_W-1:0] c;
        c = r.b1[7:5];
        return (c > SHIFT_W'(SHIFT_MAX)) ? SHIFT_W'(SHIFT_MAX) : c;
    endfunction

endpackage

// File: rtl/dsadc_sp_sync.sv
module dsadc_sp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);
    localparam int unsigned MS = STAGES - 1;

    logic [STAGES-1:0] sclk_p, csn_p, sdi_p;
    logic              sclk_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p    <= '0;
            csn_p     <= '1;
            sdi_p     <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_p    <= {sclk_p[STAGES-2:0], sclk};
            csn_p     <= {csn_p[STAGES-2:0], cs_n};
            sdi_p     <= {sdi_p[STAGES-2:0], sdi};
            sclk_last <= sclk_p[MS];
        end
    end

    assign sclk_rise = sclk_p[MS] & ~sclk_last;
    assign sclk_fall = ~sclk_p[MS] & sclk_last;
    assign cs_act    = ~csn_p[MS];
    assign sdi_s     = sdi_p[MS];
endmodule

// File: rtl/dsadc_sp_regs.sv
module dsadc_sp_regs
    import dsadc_sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output cmd_reg_t          cfg
);
    logic [BYTE_W-1:0] mem [NUM_BYTES];

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= CMD_RESET[i*BYTE_W +: BYTE_W];
            else if (wr_en && wr_addr == ADDR_W'(i))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign cfg     = {mem[3], mem[2], mem[1], mem[0]};
endmodule

// File: rtl/dsadc_sp_timer.sv
module dsadc_sp_timer
    import dsadc_sp_pkg::*;
#(
    parameter int unsigned PRESCALE   = 4,
    parameter int unsigned GUARD      = 6,
    parameter int unsigned MIN_PERIOD = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [SHIFT_W-1:0] tshift,
    input  logic               xfer_done,
    output logic               drdy_n,
    output logic               guard_ok,
    output logic               expire
);
    localparam int unsigned CNT_W   = RATIO_W + 1 + $clog2(PRESCALE);
    localparam int unsigned GUARD_W = $clog2(GUARD + 1);

    logic [CNT_W-1:0]   full, period, cnt;
    logic [GUARD_W-1:0] guard;
    logic               drdy_q;

    always_comb begin
        full   = (CNT_W'(ratio) + CNT_W'(1)) * CNT_W'(PRESCALE);
        period = full >> tshift;
        if (period < CNT_W'(MIN_PERIOD))
            period = CNT_W'(MIN_PERIOD);
    end

    assign expire = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= CNT_W'(MIN_PERIOD - 1);
            drdy_q <= 1'b1;
            guard  <= '0;
        end else begin
            cnt <= expire ? period - CNT_W'(1) : cnt - CNT_W'(1);
            if (expire)
                drdy_q <= 1'b0;
            else if (xfer_done)
                drdy_q <= 1'b1;
            if (expire && drdy_q)
                guard <= '0;
            else if (!drdy_q && guard != GUARD_W'(GUARD))
                guard <= guard + GUARD_W'(1);
        end
    end

    assign drdy_n   = drdy_q;
    assign guard_ok = !drdy_q && (guard == GUARD_W'(GUARD));
endmodule

// File: rtl/dsadc_sp_xfer.sv
module dsadc_sp_xfer
    import dsadc_sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              sdi,
    input  logic              accept_ok,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tx_bit,
    output logic              rd_phase,
    output logic              xfer_done,
    output logic              bit_take,
    output xfer_st_e          state
);
    xfer_st_e          st;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] rx, tx, rx_nxt;
    logic              cur_rd, load_tx, byte_end;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        left;
    instr_t            dec;

    assign bit_take = sclk_rise && cs_act && accept_ok && (st == ST_INSTR || st == ST_DATA);
    assign rx_nxt   = {rx[BYTE_W-2:0], sdi};
    assign byte_end = bit_take && (bitcnt == 3'd7);
    assign dec      = decode_instr(rx_nxt);

    assign xfer_done = byte_end && ((st == ST_INSTR && dec.nbytes == 2'd0) ||
                                    (st == ST_DATA && left == 2'd1));
    assign wr_en     = byte_end && (st == ST_DATA) && !cur_rd;
    assign wr_addr   = cur_addr;
    assign wr_data   = rx_nxt;
    assign rd_addr   = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            cur_rd   <= 1'b0;
            cur_addr <= '0;
            left     <= '0;
            load_tx  <= 1'b0;
        end else if (!cs_act) begin
            st      <= ST_IDLE;
            bitcnt  <= '0;
            load_tx <= 1'b0;
        end else begin
            load_tx <= 1'b0;
            if (load_tx)
                tx <= rd_data;
            else if (sclk_fall && st == ST_DATA && cur_rd && bitcnt != 3'd0)
                tx <= {tx[BYTE_W-2:0], 1'b0};
            if (st == ST_IDLE) begin
                st     <= ST_INSTR;
                bitcnt <= '0;
            end
            if (bit_take) begin
                rx     <= rx_nxt;
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    if (st == ST_INSTR) begin
                        if (dec.nbytes == 2'd0) begin
                            st <= ST_DONE;
                        end else begin
                            st       <= ST_DATA;
                            cur_rd   <= dec.rd;
                            cur_addr <= dec.addr;
                            left     <= dec.nbytes;
                            load_tx  <= 1'b1;
                        end
                    end else begin
                        left     <= left - 2'd1;
                        cur_addr <= cur_addr - ADDR_W'(1);
                        if (left == 2'd1)
                            st <= ST_DONE;
                        else
                            load_tx <= 1'b1;
                    end
                end
            end
        end
    end

    assign tx_bit   = tx[BYTE_W-1];
    assign rd_phase = (st == ST_DATA) && cur_rd;
    assign state    = st;
endmodule

// File: rtl/dsadc_serial_port.sv
module dsadc_serial_port
    import dsadc_sp_pkg::*;
#(
    parameter int unsigned PRESCALE    = 4,
    parameter int unsigned GUARD       = 6,
    parameter int unsigned MIN_PERIOD  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe,
    output logic sdout,
    output logic drdy_n
);
    logic              sclk_rise, sclk_fall, cs_act, sdi_s;
    logic              guard_ok, expire, xfer_done, bit_take;
    logic              wr_en, tx_bit, rd_phase, out_sel;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;
    cmd_reg_t          cfg;
    xfer_st_e          xfer_st;

    dsadc_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdio_in),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .sdi_s(sdi_s)
    );

    dsadc_sp_timer #(.PRESCALE(PRESCALE), .GUARD(GUARD), .MIN_PERIOD(MIN_PERIOD)) u_timer (
        .clk(clk), .rst(rst), .ratio(ratio_of(cfg)), .tshift(shift_of(cfg)),
        .xfer_done(xfer_done), .drdy_n(drdy_n), .guard_ok(guard_ok), .expire(expire)
    );

    dsadc_sp_xfer u_xfer (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_act(cs_act), .sdi(sdi_s), .accept_ok(guard_ok), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .tx_bit(tx_bit), .rd_phase(rd_phase), .xfer_done(xfer_done),
        .bit_take(bit_take), .state(xfer_st)
    );

    dsadc_sp_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg(cfg)
    );

    assign out_sel  = cfg.b3[OUTSEL_BIT];
    assign sdio_oe  = rd_phase && !out_sel;
    assign sdio_out = rd_phase && !out_sel && tx_bit;
    assign sdout    = rd_phase && out_sel && tx_bit;
endmodule

// File: rtl/dsadc_serial_port_chk.sv
module dsadc_serial_port_chk
    import dsadc_sp_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     drdy_n,
    input logic     sdio_oe,
    input logic     sdout,
    input logic     sclk_rise,
    input logic     bit_take,
    input logic     cs_act,
    input xfer_st_e st,
    input logic     expire,
    input logic     wr_en,
    input logic     sel
);
    // R5
    drdy_fall_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_n) |-> $past(expire));

    // R6
    drdy_rise_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> $past(sclk_rise));

    // R7
    bit_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        bit_take |-> !drdy_n);

    // R8
    cs_release_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (st == ST_IDLE));

    // R3
    write_in_data_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (st == ST_DATA && cs_act));

    // R9
    sel_no_oe_chk: assert property (@(posedge clk) disable iff (rst)
        sel |-> !sdio_oe);

    // R9
    pins_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> !sdout);
endmodule

bind dsadc_serial_port dsadc_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .drdy_n(drdy_n), .sdio_oe(sdio_oe), .sdout(sdout),
    .sclk_rise(sclk_rise), .bit_take(bit_take), .cs_act(cs_act), .st(xfer_st),
    .expire(expire), .wr_en(wr_en), .sel(out_sel)
);

// File: tb/dsadc_serial_port_tb.sv
module dsadc_serial_port_tb;
    localparam int HALF     = 6;
    localparam int PRESCALE = 4;
    localparam int MINP     = 16;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdout, drdy_n;

    int    checks = 0, errors = 0, oe_bad = 0;
    longint cyc = 0;
    bit    finished = 0, rd_now = 0;
    logic [7:0] m [4];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsadc_serial_port u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdout(sdout), .drdy_n(drdy_n)
    );

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_period(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        int r, t, p;
        r = {b2[2:0], b0};
        t = (b1[7:5] > 3'd4) ? 4 : int'(b1[7:5]);
        p = ((r + 1) * PRESCALE) >> t;
        return (p < MINP) ? MINP : p;
    endfunction

    task automatic wait_drdy_low();
        while (drdy_n !== 1'b0) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic o);
        sdio_in = b;
        repeat (HALF) @(negedge clk);
        if (m[3][6]) begin
            o = sdout;
            if (sdio_oe !== 1'b0) oe_bad++;
        end else begin
            o = sdio_out;
            if (rd_now && (sdio_oe !== 1'b1 || sdout !== 1'b0)) oe_bad++;
        end
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] ins, input int n, input logic [23:0] wd, output logic [23:0] rd);
        logic o;
        rd = '0;
        wait_drdy_low();
        repeat (10) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 0; i--) sbit(ins[i], o);
        rd_now = ins[7];
        for (int k = 0; k < n; k++)
            for (int i = 7; i >= 0; i--) begin
                sbit(wd[16 - 8*k + i], o);
                rd = {rd[22:0], o};
            end
        rd_now = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic partial(input logic [7:0] ins, input int ins_bits, input int data_bits);
        logic o;
        wait_drdy_low();
        repeat (10) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < ins_bits; i++) sbit(ins[7 - i], o);
        for (int i = 0; i < data_bits; i++) sbit(i[0], o);
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr1(input int a, input logic [7:0] v);
        logic [23:0] rd;
        xfer(8'h04 | 8'(3 - a), 1, {v, 16'h0}, rd);
        m[a] = v;
    endtask

    task automatic rd1(input int a, output logic [7:0] v);
        logic [23:0] rd;
        xfer(8'h84 | 8'(3 - a), 1, 24'h0, rd);
        v = rd[7:0];
    endtask

    task automatic wr3(input logic [7:0] v2, input logic [7:0] v1, input logic [7:0] v0);
        logic [23:0] rd;
        xfer(8'h05, 3, {v2, v1, v0}, rd);
        m[2] = v2; m[1] = v1; m[0] = v0;
    endtask

    task automatic check_all(input string req);
        logic [23:0] rd;
        logic [7:0]  v;
        xfer(8'h85, 3, 24'h0, rd);
        chk_eq(req, "bytes 2,1,0", rd, {m[2], m[1], m[0]});
        rd1(3, v);
        chk_eq(req, "byte3", v, m[3]);
    endtask

    task automatic measure(output longint p);
        logic [23:0] rd;
        longint t1;
        wait_drdy_low();
        t1 = cyc;
        xfer(8'h00, 0, 24'h0, rd);
        while (drdy_n !== 1'b1) @(negedge clk);
        while (drdy_n !== 1'b0) @(negedge clk);
        p = cyc - t1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] rd;
        logic [7:0]  v, v2;
        longint      p;
        int          op;
        logic        o;
        void'($urandom(32'd2718));
        m[0] = 8'h17; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h00;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the pins
        chk_eq("R1", "drdy_n after reset", drdy_n, 1);
        chk_eq("R1", "sdio_oe after reset", sdio_oe, 0);
        chk_eq("R1", "sdout after reset", sdout, 0);
        check_all("R1");

        // R3 three-byte write in order byte2, byte1, byte0; R2 asymmetric values
        wr3(8'h07, 8'h80, 8'hFF);
        check_all("R3");

        // R5 speed-up field 80h gives a 16x shorter period
        measure(p);
        chk_eq("R5", "period turbo16", p, exp_period(m[0], m[1], m[2]));

        // R2 single-byte write and read back, MSB first
        wr1(0, 8'hC3);
        rd1(0, v);
        chk_eq("R2", "byte0 readback", v, 8'hC3);

        // R5 ratio 195 without speed-up
        wr3(8'h00, 8'h00, 8'hC3);
        measure(p);
        chk_eq("R5", "period ratio 195", p, exp_period(m[0], m[1], m[2]));
        wr3(8'h07, 8'h80, 8'hFF);

        // R4 / R6 instruction without data bytes
        xfer(8'h00, 0, 24'h0, rd);
        chk_eq("R6", "drdy_n after done", drdy_n, 1);
        xfer(8'h83, 0, 24'h0, rd);
        chk_eq("R4", "drdy_n after read no-op", drdy_n, 1);
        check_all("R4");

        // R7 edges while drdy_n high and right after its fall are ignored
        xfer(8'h00, 0, 24'h0, rd);
        cs_n = 1'b0;
        sdio_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; repeat (HALF) @(negedge clk);
            sclk = 1'b0; repeat (HALF) @(negedge clk);
        end
        wait_drdy_low();
        sclk = 1'b1; @(negedge clk);
        sclk = 1'b0; @(negedge clk);
        xfer(8'h07, 1, {8'hA5, 16'h0}, rd);
        m[0] = 8'hA5;
        rd1(0, v);
        chk_eq("R7", "byte0 after gated edges", v, 8'hA5);

        // R8 abort in the instruction and in the data byte
        partial(8'hF0, 4, 0);
        chk_eq("R8", "drdy_n after abort", drdy_n, 0);
        wr1(0, 8'h3C);
        rd1(0, v);
        chk_eq("R8", "byte0 after instr abort", v, 8'h3C);
        partial(8'h07, 8, 4);
        rd1(0, v);
        chk_eq("R8", "byte0 after data abort", v, 8'h3C);

        // R9 output pin select
        wr1(3, 8'h42);
        oe_bad = 0;
        rd1(0, v);
        chk_eq("R9", "byte0 via sdout", v, 8'h3C);
        rd1(3, v);
        chk_eq("R9", "byte3 via sdout", v, 8'h42);
        chk_eq("R9", "oe faults in sdout mode", oe_bad, 0);
        wr1(3, 8'h00);
        oe_bad = 0;
        rd1(0, v);
        chk_eq("R9", "byte0 via sdio", v, 8'h3C);
        chk_eq("R9", "oe faults in sdio mode", oe_bad, 0);

        // R3 R5 random writes checked against the model
        for (int it = 0; it < 10; it++) begin
            op = $urandom % 3;
            v  = 8'($urandom);
            v2 = 8'($urandom) & 8'hF8;
            if (op == 0) wr1(0, v);
            else if (op == 1) wr1(1, v);
            else wr3(v2, 8'($urandom), v);
            check_all("R3");
            if (exp_period(m[0], m[1], m[2]) > 200) begin
                measure(p);
                chk_eq("R5", "random period", p, exp_period(m[0], m[1], m[2]));
            end
        end
        o = 1'b0;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule